// File: doc/BRIEF.md
# Sampled Modem Line Change Detector

This block watches a set of slow modem status inputs, such as clear-to-send and carrier-detect. Each input first passes through a multi-flop synchronizer. A prescaler on the system clock then samples it on a periodic tick, nominally every 8 ms. A new level counts as a change only when two consecutive ticks both return it. A single sample that differs from the held level is dropped.

When reporting is enabled, a confirmed change sets a sticky per-line flag, and any set flag drives the interrupt request. The host clears all flags with a one-cycle acknowledge pulse. A read request returns, one cycle later, the filtered line levels together with the current value of a general-purpose output bit. The host sets that bit with a simple write strobe, and it is high after reset.

The block uses only the system clock. Detection therefore continues while the serial bit clocks are stopped.

Top module: `modem_line_monitor`

## Requirements
- R1: Each synchronized input is sampled once every TICK_DIV system clocks, and a filtered level changes only as a result of such a sample.
- R2: A filtered level takes a new value only when two successive samples both differ from it. An excursion that lasts one tick period or less leaves the level and the flags unchanged.
- R3: No change is reported within TICK_DIV clocks of an input edge. A change held steady is reported within 2*TICK_DIV+5 clocks.
- R4: With report_en low, filtered levels still follow confirmed changes but no flag is set. Raising report_en later does not report a change confirmed while it was low.
- R5: A confirmed change with report_en high sets the line's bit in chg_flag and the bit stays set. A one-cycle ack pulse clears all bits of chg_flag.
- R6: irq is high exactly when at least one bit of chg_flag is set.
- R7: After reset, the first sample loads the filtered levels directly, and that load reports no change.
- R8: A one-cycle rd_req gives rd_valid high on the following cycle. At the same time rd_data carries the filtered level of line i in bit i and the general-purpose output in bit N_LINES.
- R9: gpo_out is 1 after reset, and a gpo_wr pulse loads gpo_wr_val into it on the next clock.
- R10: While reset is asserted and right after it is released, chg_flag is 0, irq is 0 and rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINES | Raw modem status inputs |
| report_en | input | 1 | Enables change reporting |
| ack | input | 1 | Clears all change flags |
| gpo_wr | input | 1 | Write strobe for the output bit |
| gpo_wr_val | input | 1 | Value loaded by gpo_wr |
| rd_req | input | 1 | Status read request |
| rd_valid | output | 1 | rd_data valid for one cycle |
| rd_data | output | N_LINES+1 | {gpo, filtered levels} |
| chg_flag | output | N_LINES | Sticky per-line change flags |
| irq | output | 1 | Interrupt request |
| gpo_out | output | 1 | General-purpose output level |

## Verification
The embedded properties check the following on every cycle:
- a level moves and a confirmation pulse appears only right after a tick;
- ticks never come back to back;
- a new flag bit requires report_en in the previous cycle;
- an acknowledge with no coincident confirmation empties the flags;
- the read and write strobes have the stated one-cycle effects.

Some behaviour only the bench's scenarios can show:
- that a one-period glitch is rejected;
- that the latency stays inside its bounds;
- that the initial load is silent;
- that a change confirmed while reporting was disabled stays unreported.

// File: rtl/mdet_pkg.sv
package mdet_pkg;
   typedef enum logic [1:0] {
      FLT_LOAD   = 2'd0,
      FLT_STEADY = 2'd1,
      FLT_PEND   = 2'd2
   } flt_state_e;
endpackage

// File: rtl/mdet_tick_gen.sv
module mdet_tick_gen #(
   parameter int TICK_DIV = 64000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(TICK_DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= RELOAD;
      else if (cnt_q == '0)   cnt_q <= RELOAD;
      else                    cnt_q <= cnt_q - 1'b1;
   end

   assign tick = (cnt_q == '0);

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/mdet_sync.sv
module mdet_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/mdet_line_filter.sv
module mdet_line_filter
   import mdet_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic smp,
   output logic level,
   output logic chg
);
   flt_state_e state_q;
   logic       level_q;
   logic       chg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FLT_LOAD;
         level_q <= 1'b0;
         chg_q   <= 1'b0;
      end else begin
         chg_q <= 1'b0;
         if (tick) begin
            unique case (state_q)
               FLT_LOAD: begin
                  level_q <= smp;
                  state_q <= FLT_STEADY;
               end
               FLT_STEADY: begin
                  if (smp != level_q) state_q <= FLT_PEND;
               end
               FLT_PEND: begin
                  if (smp != level_q) begin
                     level_q <= smp;
                     chg_q   <= 1'b1;
                  end
                  state_q <= FLT_STEADY;
               end
               default: state_q <= FLT_LOAD;
            endcase
         end
      end
   end

   assign level = level_q;
   assign chg   = chg_q;

   // R1
   level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(level_q));
   // R2
   chg_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |-> $past(tick));
   // R7
   no_chg_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && state_q == FLT_LOAD) |=> !chg_q);
endmodule

// File: rtl/modem_line_monitor.sv
module modem_line_monitor #(
   parameter int N_LINES     = 2,
   parameter int TICK_DIV    = 64000,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] line_in,
   input  logic               report_en,
   input  logic               ack,
   input  logic               gpo_wr,
   input  logic               gpo_wr_val,
   input  logic               rd_req,
   output logic               rd_valid,
   output logic [N_LINES:0]   rd_data,
   output logic [N_LINES-1:0] chg_flag,
   output logic               irq,
   output logic               gpo_out
);
   localparam int RD_W = N_LINES + 1;

   if (N_LINES < 1) begin : g_bad_lines
      $error("N_LINES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TICK_DIV < SYNC_STAGES + 2) begin : g_bad_div
      $error("TICK_DIV must exceed SYNC_STAGES + 1");
   end

   logic               tick;
   logic [N_LINES-1:0] smp_w;
   logic [N_LINES-1:0] lvl_w;
   logic [N_LINES-1:0] chg_w;
   logic [N_LINES-1:0] flag_q;
   logic               gpo_q;
   logic               rdv_q;
   logic [RD_W-1:0]    rdd_q;

   mdet_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   mdet_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in), .dout(smp_w));

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      mdet_line_filter i_flt (
         .clk(clk), .rst_n(rst_n), .tick(tick), .smp(smp_w[i]),
         .level(lvl_w[i]), .chg(chg_w[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & {N_LINES{~ack}}) | (chg_w & {N_LINES{report_en}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gpo_q <= 1'b1;
      else if (gpo_wr) gpo_q <= gpo_wr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdv_q <= 1'b0;
         rdd_q <= '0;
      end else begin
         rdv_q <= rd_req;
         if (rd_req) rdd_q <= {gpo_q, lvl_w};
      end
   end

   assign chg_flag = flag_q;
   assign irq      = |flag_q;
   assign gpo_out  = gpo_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;

   // R4
   flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(chg_flag & ~$past(chg_flag))) |-> $past(report_en));
   // R5
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && chg_w == '0) |=> (chg_flag == '0));
   // R6
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(ack));
   // R8
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   // R9
   gpo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gpo_wr |=> (gpo_out == $past(gpo_wr_val)));
endmodule

// File: tb/test_modem_line_monitor.sv
module test_modem_line_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 2;
   localparam int DIV = 16;
   localparam int SETTLE = 3*DIV + 5;

   // vector: [6:5] lines, [4] report_en, [3:2] expected flags, [1:0] expected levels
   localparam logic [6:0] VEC [6] = '{
      7'b01_1_01_01,
      7'b11_1_10_11,
      7'b00_1_11_00,
      7'b10_0_00_10,
      7'b10_1_00_10,
      7'b01_1_11_01
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] line_in = '0;
   logic         report_en = 1'b0;
   logic         ack = 1'b0;
   logic         gpo_wr = 1'b0;
   logic         gpo_wr_val = 1'b0;
   logic         rd_req = 1'b0;
   logic         rd_valid;
   logic [N:0]   rd_data;
   logic [N-1:0] chg_flag;
   logic         irq;
   logic         gpo_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_line_monitor #(.N_LINES(N), .TICK_DIV(DIV), .SYNC_STAGES(2)) i_modem_line_monitor (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .report_en(report_en),
      .ack(ack), .gpo_wr(gpo_wr), .gpo_wr_val(gpo_wr_val), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_data(rd_data), .chg_flag(chg_flag),
      .irq(irq), .gpo_out(gpo_out));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read(input string req, input logic [N:0] exp);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
      chk({req, " rd_data"}, 32'(rd_data), 32'(exp));
      @(negedge clk);
      chk({req, " rd_valid drop"}, 32'(rd_valid), 32'd0);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      line_in = 2'b10;
      report_en = 1'b1;
      cyc(5);
      chk("R10 flags in reset", 32'(chg_flag), 0);
      chk("R10 irq in reset", 32'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 flags after reset", 32'(chg_flag), 0);
      chk("R10 irq after reset", 32'(irq), 0);
      chk("R10 rd_valid after reset", 32'(rd_valid), 0);
      chk("R9 gpo reset high", 32'(gpo_out), 1);

      // R7 initial load is silent
      cyc(SETTLE);
      chk("R7 no flag on load", 32'(chg_flag), 0);
      do_read("R7 R8 loaded levels", 3'b110);

      // R4 disabled reporting still tracks levels
      report_en = 1'b0;
      line_in = 2'b00;
      cyc(SETTLE);
      chk("R4 no flag while disabled", 32'(chg_flag), 0);
      do_read("R4 level tracks", 3'b100);

      for (int v = 0; v < 6; v++) begin
         report_en = VEC[v][4];
         line_in   = VEC[v][6:5];
         cyc(SETTLE);
         chk($sformatf("R5 R4 vec%0d flags", v), 32'(chg_flag), 32'(VEC[v][3:2]));
         chk($sformatf("R6 vec%0d irq", v), 32'(irq), 32'(VEC[v][3:2] != 2'b00));
         do_read($sformatf("R1 R8 vec%0d levels", v), {1'b1, VEC[v][1:0]});
         do_ack();
         chk($sformatf("R5 vec%0d ack clears", v), 32'(chg_flag), 0);
         chk($sformatf("R6 vec%0d irq clears", v), 32'(irq), 0);
      end

      // R2 single-period glitch on line 0 (held at 1)
      report_en = 1'b1;
      line_in = 2'b00;
      cyc(DIV);
      line_in = 2'b01;
      cyc(SETTLE);
      chk("R2 glitch no flag", 32'(chg_flag), 0);
      do_read("R2 glitch level kept", 3'b101);

      // R3 latency window on line 1
      line_in = 2'b11;
      cyc(DIV);
      chk("R3 not early", 32'(chg_flag), 0);
      cyc(DIV + 6);
      chk("R3 reported in time", 32'(chg_flag), 32'b10);
      do_ack();

      // R9 general-purpose output writes
      gpo_wr = 1'b1; gpo_wr_val = 1'b0;
      @(negedge clk);
      gpo_wr = 1'b0;
      chk("R9 gpo written low", 32'(gpo_out), 0);
      do_read("R8 R9 gpo in read", 3'b011);
      gpo_wr = 1'b1; gpo_wr_val = 1'b1;
      @(negedge clk);
      gpo_wr = 1'b0;
      chk("R9 gpo written high", 32'(gpo_out), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule